// File: doc/BRIEF.md
# Indirect Management Register Bridge

This block gives a host CPU access to a bank of registers sitting behind an internal management bus. The host never addresses those registers directly. Instead it uses four word-sized host registers. A packet register holds the target port, the register offset and an operation code. A write-data register carries a 16-bit value together with a go/pending flag. A read-data register returns the fetched value with a completion flag. A status register shows whether a transaction is still in flight.

To read, the host writes a packet with the read code. It then polls the read-data register until the completion flag (bit 31) comes up, and takes the value from the low bits. To write, the host first posts a packet with the write code. It then writes the value with bit 31 set, and polls until the hardware drops that bit again. The packet register is stored as soon as it is written and reads back on the next cycle, so the host can confirm the posted packet before it touches the data registers.

The management bus is modelled inside the block as a synchronous register file. Its response latency is a parameter. The register file is split into `PORT_COUNT` ports of `2**REG_AW` registers each. A control state machine sequences each transaction, and a busy interlock drops any host command that arrives while a transaction is running.

Top module: `mdioBridge`

## Requirements
- R1: Host register index 0 is the packet register, laid out as register offset in bits [15:0], port in bits [19:16] and operation code in bits [31:20]. A write to it while idle is stored whole and reads back unchanged from the next cycle on.
- R2: A packet write with operation code 1, made while idle, clears read-data bit 31 at that same clock edge and starts a read. Bit 31 of index 2 returns to 1 exactly RESP_LATENCY+1 clock edges after the packet write edge. At that point index 2 holds the register value in bits [15:0], with bits [30:16] zero.
- R3: A write to index 1 with bit 31 set, made while idle and with operation code 0 stored in the packet register, starts a write of bits [15:0] to the addressed register. Index 1 reads back as {1, 15'b0, data} until bit 31 is cleared by hardware exactly RESP_LATENCY+1 edges after that write. Once bit 31 has cleared, the register holds the new value.
- R4: A write to index 1 with bit 31 clear is ignored. It starts no transaction, index 1 reads back unchanged, and the register file is not modified.
- R5: Bit 0 of index 3 reads 1 from the edge that starts a transaction until the edge that completes it. While it is 1, host writes to index 0 and index 1 are dropped and leave both the host registers and the register file unchanged.
- R6: A transaction that names a port at or above PORT_COUNT, or a register offset at or above 2**REG_AW, still completes its handshake. A read of such a location returns 0, and a write to it changes no register (no aliasing onto valid offsets).
- R7: After reset, indexes 0 to 3 read as zero. The register file entry at flat index i = port*2**REG_AW + offset holds {i[7:0], ~i[7:0]}.
- R8: A packet whose operation code is neither 0 nor 1 is stored but starts nothing. While it is stored, writes to index 1 are ignored even with bit 31 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWrEn | input | 1 | Host write strobe, sampled at the rising edge |
| hostAddr | input | 2 | Host register index (0 packet, 1 write data, 2 read data, 3 status) |
| hostWrData | input | 32 | Host write value |
| hostRdData | output | 32 | Value of the register selected by hostAddr (combinational) |

## Verification
The bench measures the exact edge on which the read completion flag rises and the write pending flag falls, and compares it with RESP_LATENCY. A design with an extra or a missing pipeline stage in the request path would be caught by this check. It issues commands during a busy window. A design without the interlock would overwrite the posted packet or launch a second transaction that corrupts a register. It also writes the data register with bit 31 clear, and stores packets with unknown operation codes. A design that decodes too loosely would start spurious writes in these cases. Out-of-range ports and offsets are read and written. A design that truncates the address would alias such writes onto valid registers. A seeded random mix of reads and writes is checked against a model of the register file kept in the bench.

// File: rtl/mdioBridgePkg.sv
package mdioBridgePkg;

  // host register indexes
  localparam logic [1:0] IDX_ADDR   = 2'd0;
  localparam logic [1:0] IDX_WDATA  = 2'd1;
  localparam logic [1:0] IDX_RDATA  = 2'd2;
  localparam logic [1:0] IDX_STATUS = 2'd3;

  // packet layout
  localparam int unsigned CMD_LSB  = 20;
  localparam int unsigned CMD_W    = 12;
  localparam int unsigned PORT_LSB = 16;
  localparam int unsigned PORT_W   = 4;
  localparam int unsigned OFS_W    = 16;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned FLAG_BIT = 31;

  localparam logic [CMD_W-1:0] CMD_READ  = 12'd1;
  localparam logic [CMD_W-1:0] CMD_WRITE = 12'd0;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } ctrlState_t;

  typedef struct packed {
    logic latchAddr;
    logic clrRdDone;
    logic latchWdata;
    logic issue;
    logic issueWrite;
    logic finishRead;
    logic finishWrite;
  } ctrlStrobes_t;

endpackage

// File: rtl/mdioCtrl.sv
module mdioCtrl
  import mdioBridgePkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     hostWrEn,
  input  logic [1:0]               hostAddr,
  input  logic [CMD_W-1:0]         hostCmd,
  input  logic                     hostWdValid,
  input  logic [CMD_W-1:0]         storedCmd,
  input  logic                     respAck,
  output ctrlStrobes_t             strb,
  output logic                     busy
);

  ctrlState_t state;
  logic       opRead;
  logic       idle;
  logic       addrHit;
  logic       wdHit;

  assign idle    = (state == ST_IDLE);
  assign addrHit = hostWrEn && (hostAddr == IDX_ADDR);
  assign wdHit   = hostWrEn && (hostAddr == IDX_WDATA);
  assign busy    = !idle;

  always_comb begin
    strb             = '0;
    strb.latchAddr   = idle && addrHit;
    strb.clrRdDone   = idle && addrHit && (hostCmd == CMD_READ);
    strb.latchWdata  = idle && wdHit && hostWdValid && (storedCmd == CMD_WRITE);
    strb.issue       = (state == ST_ISSUE);
    strb.issueWrite  = (state == ST_ISSUE) && !opRead;
    strb.finishRead  = (state == ST_WAIT) && respAck && opRead;
    strb.finishWrite = (state == ST_WAIT) && respAck && !opRead;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      opRead <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (strb.clrRdDone) begin
            state  <= ST_ISSUE;
            opRead <= 1'b1;
          end else if (strb.latchWdata) begin
            state  <= ST_ISSUE;
            opRead <= 1'b0;
          end
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT:  if (respAck) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mdioDatapath.sv
module mdioDatapath
  import mdioBridgePkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strb,
  input  logic                 busy,
  input  logic [1:0]           hostAddr,
  input  logic [31:0]          hostWrData,
  input  logic [DATA_W-1:0]    respRdata,
  output logic [31:0]          hostRdData,
  output logic [CMD_W-1:0]     storedCmd,
  output logic [PORT_W-1:0]    reqPort,
  output logic [OFS_W-1:0]     reqOfs,
  output logic [DATA_W-1:0]    reqWdata,
  output logic [31:0]          addrPkt,
  output logic                 rdDone,
  output logic                 wrPend
);

  logic [DATA_W-1:0] wdataReg;
  logic [DATA_W-1:0] rdDataReg;

  localparam int unsigned PAD_W = 31 - DATA_W;

  assign storedCmd = addrPkt[CMD_LSB +: CMD_W];
  assign reqPort   = addrPkt[PORT_LSB +: PORT_W];
  assign reqOfs    = addrPkt[OFS_W-1:0];
  assign reqWdata  = wdataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrPkt   <= '0;
      wdataReg  <= '0;
      wrPend    <= 1'b0;
      rdDone    <= 1'b0;
      rdDataReg <= '0;
    end else begin
      if (strb.latchAddr) addrPkt <= hostWrData;
      if (strb.clrRdDone) begin
        rdDone <= 1'b0;
      end else if (strb.finishRead) begin
        rdDone    <= 1'b1;
        rdDataReg <= respRdata;
      end
      if (strb.latchWdata) begin
        wdataReg <= hostWrData[DATA_W-1:0];
        wrPend   <= 1'b1;
      end else if (strb.finishWrite) begin
        wrPend <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (hostAddr)
      IDX_ADDR:   hostRdData = addrPkt;
      IDX_WDATA:  hostRdData = {wrPend, {PAD_W{1'b0}}, wdataReg};
      IDX_RDATA:  hostRdData = {rdDone, {PAD_W{1'b0}}, rdDataReg};
      default:    hostRdData = {31'd0, busy};
    endcase
  end

endmodule

// File: rtl/mdioResponder.sv
module mdioResponder
  import mdioBridgePkg::*;
#(
  parameter int unsigned PORT_COUNT   = 2,
  parameter int unsigned REG_AW       = 4,
  parameter int unsigned RESP_LATENCY = 3
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [PORT_W-1:0]    reqPort,
  input  logic [OFS_W-1:0]     reqOfs,
  input  logic [DATA_W-1:0]    reqWdata,
  output logic                 respAck,
  output logic [DATA_W-1:0]    respRdata
);

  localparam int unsigned REGS  = 1 << REG_AW;
  localparam int unsigned DEPTH = PORT_COUNT * REGS;
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(RESP_LATENCY + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              active;
  logic [CNT_W-1:0]  cnt;
  logic              latWrite;
  logic [PORT_W-1:0] latPort;
  logic [OFS_W-1:0]  latOfs;
  logic [DATA_W-1:0] latWdata;
  logic [31:0]       flatIdx;
  logic [IDX_W-1:0]  memIdx;
  logic              inRange;

  assign flatIdx = 32'(latPort) * 32'(REGS) + 32'(latOfs);
  assign memIdx  = IDX_W'(flatIdx);
  assign inRange = (32'(latPort) < 32'(PORT_COUNT)) && (32'(latOfs) < 32'(REGS));

  assign respAck   = active && (cnt == CNT_W'(1));
  assign respRdata = inRange ? mem[memIdx] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      cnt      <= '0;
      latWrite <= 1'b0;
      latPort  <= '0;
      latOfs   <= '0;
      latWdata <= '0;
      for (int i = 0; i < int'(DEPTH); i++) begin
        mem[i] <= {8'(i), ~8'(i)};
      end
    end else begin
      if (reqValid) begin
        active   <= 1'b1;
        cnt      <= CNT_W'(RESP_LATENCY);
        latWrite <= reqWrite;
        latPort  <= reqPort;
        latOfs   <= reqOfs;
        latWdata <= reqWdata;
      end else if (active) begin
        if (cnt == CNT_W'(1)) begin
          active <= 1'b0;
          if (latWrite && inRange) mem[memIdx] <= latWdata;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/mdioBridge.sv
module mdioBridge
  import mdioBridgePkg::*;
#(
  parameter int unsigned PORT_COUNT   = 2,
  parameter int unsigned REG_AW       = 4,
  parameter int unsigned RESP_LATENCY = 3
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWrEn,
  input  logic [1:0]  hostAddr,
  input  logic [31:0] hostWrData,
  output logic [31:0] hostRdData
);

  ctrlStrobes_t      strb;
  logic              busy;
  logic              respAck;
  logic [DATA_W-1:0] respRdata;
  logic [CMD_W-1:0]  storedCmd;
  logic [PORT_W-1:0] reqPort;
  logic [OFS_W-1:0]  reqOfs;
  logic [DATA_W-1:0] reqWdata;
  logic [31:0]       addrPkt;
  logic              rdDone;
  logic              wrPend;

  mdioCtrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .hostWrEn    (hostWrEn),
    .hostAddr    (hostAddr),
    .hostCmd     (hostWrData[CMD_LSB +: CMD_W]),
    .hostWdValid (hostWrData[FLAG_BIT]),
    .storedCmd   (storedCmd),
    .respAck     (respAck),
    .strb        (strb),
    .busy        (busy)
  );

  mdioDatapath uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .busy       (busy),
    .hostAddr   (hostAddr),
    .hostWrData (hostWrData),
    .respRdata  (respRdata),
    .hostRdData (hostRdData),
    .storedCmd  (storedCmd),
    .reqPort    (reqPort),
    .reqOfs     (reqOfs),
    .reqWdata   (reqWdata),
    .addrPkt    (addrPkt),
    .rdDone     (rdDone),
    .wrPend     (wrPend)
  );

  mdioResponder #(
    .PORT_COUNT   (PORT_COUNT),
    .REG_AW       (REG_AW),
    .RESP_LATENCY (RESP_LATENCY)
  ) uResp (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (strb.issue),
    .reqWrite  (strb.issueWrite),
    .reqPort   (reqPort),
    .reqOfs    (reqOfs),
    .reqWdata  (reqWdata),
    .respAck   (respAck),
    .respRdata (respRdata)
  );

endmodule

// File: rtl/mdioBridgeChk.sv
module mdioBridgeChk (
  input logic        clk,
  input logic        rstN,
  input logic        hostWrEn,
  input logic [1:0]  hostAddr,
  input logic [31:0] hostWrData,
  input logic        busy,
  input logic        respAck,
  input logic [31:0] addrPkt,
  input logic        rdDone,
  input logic        wrPend
);

  // R2: a read command taken while idle clears the done flag at once
  assert_read_clears_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr == 2'd0 && hostWrData[31:20] == 12'd1 && !busy) |=> (!rdDone && busy));

  // R2: the done flag only rises after the responder acknowledged
  assert_done_after_ack_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdDone) |-> $past(respAck));

  // R3: pending flag only falls after the responder acknowledged
  assert_pend_after_ack_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrPend) |-> $past(respAck));

  // R4: an unflagged data write leaves the bridge idle
  assert_unflagged_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && hostWrEn && hostAddr == 2'd1 && !hostWrData[31]) |=> !busy);

  // R5: packet register is frozen while busy
  assert_busy_holds_pkt_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && hostWrEn && hostAddr == 2'd0) |=> (addrPkt == $past(addrPkt)));

  // R5: responder acknowledges only inside a busy window
  assert_ack_in_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    respAck |-> busy);

endmodule

bind mdioBridge mdioBridgeChk chk (
  .clk        (clk),
  .rstN       (rstN),
  .hostWrEn   (hostWrEn),
  .hostAddr   (hostAddr),
  .hostWrData (hostWrData),
  .busy       (busy),
  .respAck    (respAck),
  .addrPkt    (addrPkt),
  .rdDone     (rdDone),
  .wrPend     (wrPend)
);

// File: tb/tb_mdioBridge.sv
module tb_mdioBridge;

  localparam int PORTS = 2;
  localparam int RAW   = 4;
  localparam int LAT   = 3;
  localparam int REGS  = 1 << RAW;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [1:0]  hostAddr = 2'd0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;

  int nChecks = 0;
  int nFail   = 0;
  logic [15:0] model [PORTS*REGS];

  always #5 clk = ~clk;

  mdioBridge #(.PORT_COUNT(PORTS), .REG_AW(RAW), .RESP_LATENCY(LAT)) dut (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData)
  );

  function automatic logic [15:0] resetVal(input int i);
    return {8'(i), ~8'(i)};
  endfunction

  function automatic logic [31:0] pkt(input int cmd, input int port, input int ofs);
    return {12'(cmd), 4'(port), 16'(ofs)};
  endfunction

  function automatic logic [15:0] expectAt(input int port, input int ofs);
    if (port < PORTS && ofs < REGS) return model[port*REGS+ofs];
    return 16'h0;
  endfunction

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [31:0] d);
    hostWrEn = 1'b1; hostAddr = idx; hostWrData = d;
    @(posedge clk);
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] idx, output logic [31:0] v);
    hostAddr = idx;
    #1;
    v = hostRdData;
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    int n = 0;
    rdReg(2'd3, s);
    while (s[0] && n < 200) begin
      @(negedge clk);
      rdReg(2'd3, s);
      n++;
    end
  endtask

  task automatic doWrite(input int port, input int ofs, input logic [15:0] d);
    wr(2'd0, pkt(0, port, ofs));
    wr(2'd1, {1'b1, 15'd0, d});
    waitIdle();
    if (port < PORTS && ofs < REGS) model[port*REGS+ofs] = d;
  endtask

  task automatic doRead(input int port, input int ofs, output logic [31:0] v);
    wr(2'd0, pkt(1, port, ofs));
    waitIdle();
    rdReg(2'd2, v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL R5 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] keep;
    void'($urandom(32'd4711));
    for (int i = 0; i < PORTS*REGS; i++) model[i] = resetVal(i);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R7 reset state
    for (int i = 0; i < 4; i++) begin
      rdReg(2'(i), v);
      checkEq("R7 host reg reset", v, 32'd0);
    end
    doRead(1, 5, v);
    checkEq("R7 regfile reset value", v, {1'b1, 15'd0, resetVal(REGS + 5)});

    // R1 packet readback next cycle, no transaction for write code
    wr(2'd0, pkt(0, 1, 3));
    rdReg(2'd0, v);
    checkEq("R1 packet readback", v, pkt(0, 1, 3));
    rdReg(2'd3, v);
    checkEq("R1 no busy after write-code packet", v, 32'd0);

    // R4 unflagged data write ignored
    rdReg(2'd1, keep);
    wr(2'd1, {1'b0, 15'd0, 16'hBEEF});
    rdReg(2'd3, v);
    checkEq("R4 stays idle", v, 32'd0);
    rdReg(2'd1, v);
    checkEq("R4 wdata unchanged", v, keep);
    doRead(1, 3, v);
    checkEq("R4 regfile unchanged", v, {1'b1, 15'd0, expectAt(1, 3)});

    // R8 unknown opcode
    wr(2'd0, pkt(12'h5A5, 0, 1));
    rdReg(2'd0, v);
    checkEq("R8 packet stored", v, pkt(12'h5A5, 0, 1));
    rdReg(2'd3, v);
    checkEq("R8 no transaction", v, 32'd0);
    rdReg(2'd1, keep);
    wr(2'd1, {1'b1, 15'd0, 16'h7777});
    rdReg(2'd3, v);
    checkEq("R8 flagged data ignored busy", v, 32'd0);
    rdReg(2'd1, v);
    checkEq("R8 flagged data ignored wdata", v, keep);
    doRead(0, 1, v);
    checkEq("R8 regfile unchanged", v, {1'b1, 15'd0, expectAt(0, 1)});

    // R3 write timing
    wr(2'd0, pkt(0, 0, 2));
    wr(2'd1, {1'b1, 15'd0, 16'h1234});
    for (int k = 0; k <= LAT; k++) begin
      rdReg(2'd1, v);
      checkEq("R3 pending held", v, 32'h8000_1234);
      rdReg(2'd3, v);
      checkEq("R5 busy during write", v, 32'd1);
      @(negedge clk);
    end
    rdReg(2'd1, v);
    checkEq("R3 pending cleared on time", v, 32'h0000_1234);
    rdReg(2'd3, v);
    checkEq("R5 idle after write", v, 32'd0);
    model[2] = 16'h1234;

    // R2 read timing
    wr(2'd0, pkt(1, 0, 2));
    for (int k = 0; k <= LAT; k++) begin
      rdReg(2'd2, v);
      checkEq("R2 done low while reading", {31'd0, v[31]}, 32'd0);
      @(negedge clk);
    end
    rdReg(2'd2, v);
    checkEq("R2 done and data on time", v, 32'h8000_1234);

    // R5 commands dropped while busy
    wr(2'd0, pkt(1, 1, 4));
    wr(2'd0, pkt(1, 0, 7));
    wr(2'd1, {1'b1, 15'd0, 16'hDEAD});
    rdReg(2'd0, v);
    checkEq("R5 packet held while busy", v, pkt(1, 1, 4));
    waitIdle();
    rdReg(2'd2, v);
    checkEq("R5 first read result", v, {1'b1, 15'd0, expectAt(1, 4)});
    rdReg(2'd1, v);
    checkEq("R5 wdata not taken while busy", v, 32'h0000_1234);
    doRead(1, 4, v);
    checkEq("R5 regfile not corrupted", v, {1'b1, 15'd0, expectAt(1, 4)});

    // R6 out-of-range accesses
    doWrite(3, 2, 16'hCAFE);
    doRead(3, 2, v);
    checkEq("R6 bad port reads zero", v, 32'h8000_0000);
    doWrite(0, REGS + 2, 16'h5555);
    doRead(0, REGS + 2, v);
    checkEq("R6 bad offset reads zero", v, 32'h8000_0000);
    doRead(0, 2, v);
    checkEq("R6 no aliasing", v, 32'h8000_1234);

    // random mix (R2, R3)
    for (int n = 0; n < 60; n++) begin
      int port = int'($urandom % 3);
      int ofs  = int'($urandom % (REGS + 4));
      if ($urandom % 2 == 0) begin
        logic [15:0] d = 16'($urandom);
        doWrite(port, ofs, d);
        rdReg(2'd1, v);
        checkEq("R3 random write completes", v, {16'd0, d});
      end else begin
        doRead(port, ofs, v);
        checkEq("R2 random read data", v, {1'b1, 15'd0, expectAt(port, ofs)});
      end
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule